// File: doc/BRIEF.md
# Receive-side automatic RTS flow controller

This block drives the active-low RTS output of one UART receive channel. It watches a 16-entry receive FIFO, and it decides when the remote transmitter must pause. It does not drop RTS at a fill threshold. It drops RTS in the middle of the last character that can still be stored: this happens when that character's first data bit arrives and the FIFO already holds 15 bytes. RTS is given back once there is room again. That room comes either from free space or from the first read of a full buffer.

The block does not contain the baud generator, the deserializer or the FIFO storage. It only observes their status signals:
- the FIFO occupancy count;
- a one-cycle strobe at the first data bit of each incoming character;
- a busy flag that is high while a character is being assembled;
- a one-cycle pulse for each read of the receive buffer.

When automatic mode is off, RTS follows a software request bit.

The controller is a four-state machine:
- **MANUAL**: automatic mode is off, and RTS mirrors the software bit.
- **OPEN**: RTS is asserted.
- **HOLD**: RTS is deasserted while the last character that fits is still arriving, or afterwards.
- **FULL**: RTS is deasserted, the FIFO is full, and the block waits for a read.

The transitions are:
- MANUAL→OPEN when automatic mode is enabled.
- Any state→MANUAL when automatic mode is disabled.
- OPEN→HOLD when the first-bit strobe arrives with the count at 15 or more.
- HOLD→OPEN when two or more entries are free, or when exactly one entry is free and the busy flag is low, or when a read arrives with the count at 16.
- HOLD→FULL when the count reaches 16 without a read.
- FULL→OPEN when a read arrives.

RTS is registered. It changes on the same clock edge as the state, one cycle after the inputs that cause the change.

Top module: `arts_flow_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first edge after reset is released, `rts_n` is 0. The controller starts in OPEN.
- R2: While `auto_en` is 0, `rts_n` equals the inverse of `sw_rts` sampled on the previous edge. In that mode the FIFO status inputs have no effect on `rts_n`.
- R3: In OPEN, a `first_bit` pulse with `fill_count` ≥ 15 sets `rts_n` to 1 one cycle later. A `first_bit` pulse with `fill_count` ≤ 14 leaves `rts_n` at 0. This includes counts at the 14-byte trigger level.
- R4: In HOLD, when `fill_count` ≤ 14 (two or more entries free), `rts_n` returns to 0 one cycle later, whatever the value of `rx_busy`.
- R5: In HOLD, when `fill_count` = 15 and `rx_busy` = 0, `rts_n` returns to 0 one cycle later.
- R6: In HOLD, when `fill_count` = 15 and `rx_busy` = 1, `rts_n` stays 1.
- R7: In HOLD or FULL with `fill_count` = 16, `rts_n` stays 1 until an `rbr_read` pulse arrives. The first such pulse sets `rts_n` to 0 one cycle later.
- R8: When `auto_en` rises, the controller enters OPEN and `rts_n` is 0 one cycle later, whatever the value of `sw_rts`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | 1 selects automatic RTS control |
| sw_rts | input | 1 | Software RTS request (1 = assert) used while automatic mode is off |
| fill_count | input | CNT_W (5) | Receive FIFO occupancy, 0 to DEPTH |
| first_bit | input | 1 | One-cycle strobe at the first data bit of an incoming character |
| rx_busy | input | 1 | High while a character is being assembled |
| rbr_read | input | 1 | One-cycle pulse for a receive buffer read |
| rts_n | output | 1 | Registered active-low RTS |

## Verification
The assertions assume the following about the inputs:
- `fill_count` never exceeds DEPTH.
- `first_bit` and `rbr_read` are single-cycle pulses.
- Reads only arrive when the FIFO holds data.

Under these assumptions, each property relates the state and inputs at one edge to `rts_n` at the next edge. The bench keeps within these assumptions: it holds the count between 0 and 16 and drives every strobe for exactly one cycle. It sweeps every count value under both busy levels, both from OPEN and from HOLD. It resets between cases so that every case starts from a known state.

// File: rtl/arts_pkg.sv
package arts_pkg;
    typedef enum logic [1:0] {
        ST_MANUAL = 2'd0,
        ST_OPEN   = 2'd1,
        ST_HOLD   = 2'd2,
        ST_FULL   = 2'd3
    } arts_state_e;
endpackage

// File: rtl/arts_space_eval.sv
module arts_space_eval #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] fill_count,
    output logic             last_slot,
    output logic             room_one,
    output logic             room_many,
    output logic             at_full
);
    localparam logic [CNT_W-1:0] LAST_LVL = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    always_comb begin
        last_slot = (fill_count >= LAST_LVL);
        room_one  = (fill_count == LAST_LVL);
        room_many = (fill_count <  LAST_LVL);
        at_full   = (fill_count >= FULL_LVL);
    end
endmodule

// File: rtl/arts_fsm.sv
module arts_fsm
    import arts_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        auto_en,
    input  logic        first_bit,
    input  logic        rx_busy,
    input  logic        rbr_read,
    input  logic        last_slot,
    input  logic        room_one,
    input  logic        room_many,
    input  logic        at_full,
    output arts_state_e state_q,
    output arts_state_e state_d
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!auto_en) begin
            state_d = ST_MANUAL;
        end else begin
            unique case (state_q)
                ST_MANUAL: state_d = ST_OPEN;
                ST_OPEN: begin
                    if (first_bit && last_slot) state_d = ST_HOLD;
                end
                ST_HOLD: begin
                    if (room_many || (room_one && !rx_busy)) state_d = ST_OPEN;
                    else if (at_full && rbr_read)            state_d = ST_OPEN;
                    else if (at_full)                        state_d = ST_FULL;
                end
                ST_FULL: begin
                    if (rbr_read) state_d = ST_OPEN;
                end
                default: state_d = ST_OPEN;
            endcase
        end
    end
endmodule

// File: rtl/arts_rts_reg.sv
module arts_rts_reg
    import arts_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  arts_state_e state_d,
    input  logic        sw_rts,
    output logic        rts_n
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rts_n <= 1'b0;
        end else begin
            unique case (state_d)
                ST_MANUAL: rts_n <= ~sw_rts;
                ST_OPEN:   rts_n <= 1'b0;
                ST_HOLD:   rts_n <= 1'b1;
                ST_FULL:   rts_n <= 1'b1;
                default:   rts_n <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/arts_flow_ctrl.sv
module arts_flow_ctrl
    import arts_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic             sw_rts,
    input  logic [CNT_W-1:0] fill_count,
    input  logic             first_bit,
    input  logic             rx_busy,
    input  logic             rbr_read,
    output logic             rts_n
);
    logic        last_slot, room_one, room_many, at_full;
    arts_state_e state_q, state_d;

    arts_space_eval #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_space (
        .fill_count (fill_count),
        .last_slot  (last_slot),
        .room_one   (room_one),
        .room_many  (room_many),
        .at_full    (at_full)
    );

    arts_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_en   (auto_en),
        .first_bit (first_bit),
        .rx_busy   (rx_busy),
        .rbr_read  (rbr_read),
        .last_slot (last_slot),
        .room_one  (room_one),
        .room_many (room_many),
        .at_full   (at_full),
        .state_q   (state_q),
        .state_d   (state_d)
    );

    arts_rts_reg u_rts (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_d (state_d),
        .sw_rts  (sw_rts),
        .rts_n   (rts_n)
    );
endmodule

// File: rtl/arts_flow_ctrl_chk.sv
module arts_flow_ctrl_chk
    import arts_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             auto_en,
    input logic             sw_rts,
    input logic [CNT_W-1:0] fill_count,
    input logic             first_bit,
    input logic             rx_busy,
    input logic             rbr_read,
    input logic             rts_n,
    input arts_state_e      state
);
    localparam logic [CNT_W-1:0] LAST_LVL = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    p_reset_open_r1: assert property (@(posedge clk)
        !rst_n |=> !rts_n);

    p_manual_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> (rts_n == !$past(sw_rts)));

    p_drop_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && state == ST_OPEN && first_bit && fill_count >= LAST_LVL) |=> rts_n);

    p_keep_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && state == ST_OPEN && !(first_bit && fill_count >= LAST_LVL)) |=> !rts_n);

    p_room_many_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && state == ST_HOLD && fill_count < LAST_LVL) |=> !rts_n);

    p_room_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && state == ST_HOLD && fill_count == LAST_LVL && !rx_busy) |=> !rts_n);

    p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && state == ST_HOLD && fill_count == LAST_LVL && rx_busy) |=> rts_n);

    p_full_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && state != ST_OPEN && state != ST_MANUAL &&
         fill_count == FULL_LVL && !rbr_read) |=> rts_n);

    p_full_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && state != ST_OPEN && state != ST_MANUAL &&
         fill_count == FULL_LVL && rbr_read) |=> !rts_n);

    p_enable_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && state == ST_MANUAL) |=> (!rts_n && state == ST_OPEN));
endmodule

bind arts_flow_ctrl arts_flow_ctrl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_en    (auto_en),
    .sw_rts     (sw_rts),
    .fill_count (fill_count),
    .first_bit  (first_bit),
    .rx_busy    (rx_busy),
    .rbr_read   (rbr_read),
    .rts_n      (rts_n),
    .state      (state_q)
);

// File: tb/tb_arts_flow_ctrl.sv
`timescale 1ns/1ps
module tb_arts_flow_ctrl;
    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             auto_en = 1'b1;
    logic             sw_rts = 1'b0;
    logic [CNT_W-1:0] fill_count = '0;
    logic             first_bit = 1'b0;
    logic             rx_busy = 1'b0;
    logic             rbr_read = 1'b0;
    logic             rts_n;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    arts_flow_ctrl #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .sw_rts(sw_rts),
        .fill_count(fill_count), .first_bit(first_bit), .rx_busy(rx_busy),
        .rbr_read(rbr_read), .rts_n(rts_n)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic exp);
        n_tests = n_tests + 1;
        if (rts_n !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: rts_n actual %b expected %b", req, rts_n, exp);
        end
    endtask

    task automatic do_reset(input logic en);
        rst_n = 1'b0; auto_en = en; sw_rts = 1'b0; fill_count = '0;
        first_bit = 1'b0; rx_busy = 1'b0; rbr_read = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    // Bring the controller from OPEN into HOLD (R3 path).
    task automatic enter_hold();
        fill_count = CNT_W'(DEPTH - 1);
        rx_busy = 1'b1;
        first_bit = 1'b1;
        step();
        first_bit = 1'b0;
        check("R3", 1'b1);
    endtask

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        step();
        check("R1", 1'b0);
        rst_n = 1'b1;
        step();
        check("R1", 1'b0);

        // R3: first-bit strobe at every count from OPEN
        for (int f = 0; f <= DEPTH; f++) begin
            for (int b = 0; b < 2; b++) begin
                do_reset(1'b1);
                fill_count = CNT_W'(f);
                rx_busy = b[0];
                first_bit = 1'b1;
                step();
                first_bit = 1'b0;
                check("R3", (f >= DEPTH - 1) ? 1'b1 : 1'b0);
            end
        end

        // R4 / R5 / R6 / R7: release sweep from HOLD
        for (int f = 0; f <= DEPTH; f++) begin
            for (int b = 0; b < 2; b++) begin
                do_reset(1'b1);
                enter_hold();
                fill_count = CNT_W'(f);
                rx_busy = b[0];
                step();
                if (f <= DEPTH - 2)      check("R4", 1'b0);
                else if (f == DEPTH - 1) check(b ? "R6" : "R5", b[0]);
                else                     check("R7", 1'b1);
            end
        end

        // R6: hold persists over several busy cycles at 15
        do_reset(1'b1);
        enter_hold();
        for (int i = 0; i < 4; i++) begin
            step();
            check("R6", 1'b1);
        end
        rx_busy = 1'b0;
        step();
        check("R5", 1'b0);

        // R7: full, wait, then first read releases
        do_reset(1'b1);
        enter_hold();
        fill_count = CNT_W'(DEPTH);
        rx_busy = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step();
            check("R7", 1'b1);
        end
        rbr_read = 1'b1;
        step();
        rbr_read = 1'b0;
        fill_count = CNT_W'(DEPTH - 1);
        check("R7", 1'b0);
        step();
        check("R7", 1'b0);

        // R7: read while still in HOLD at full count
        do_reset(1'b1);
        enter_hold();
        fill_count = CNT_W'(DEPTH);
        rbr_read = 1'b1;
        step();
        rbr_read = 1'b0;
        check("R7", 1'b0);

        // R2: manual mode follows software bit, ignores FIFO status
        do_reset(1'b0);
        for (int s = 0; s < 4; s++) begin
            sw_rts = s[0];
            fill_count = CNT_W'(DEPTH - 1);
            first_bit = 1'b1;
            rx_busy = 1'b1;
            step();
            first_bit = 1'b0;
            check("R2", ~s[0]);
        end

        // R8: enabling from manual with software deasserted
        do_reset(1'b0);
        sw_rts = 1'b0;
        step();
        check("R2", 1'b1);
        auto_en = 1'b1;
        step();
        check("R8", 1'b0);

        // R8: disabling from HOLD drops to manual value
        do_reset(1'b1);
        enter_hold();
        auto_en = 1'b0;
        sw_rts = 1'b1;
        step();
        check("R2", 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule